// File: doc/BRIEF.md
# Edge-Triggered Maskable Interrupt Controller

This block collects up to eight single-bit interrupt sources for a small processor core and turns them into one interrupt request line. Each source is watched for a transition. By default that is a low-to-high transition. A per-bit elaboration parameter can select the high-to-low transition for that source instead. Each enabled transition sets a bit in a captured trigger vector. A qualifying transition that arrives while no handler is running raises the request to the core. The request stays up until the core takes it.

The core talks to the block through its I/O port strobes. An input-port read at the trigger index returns the captured vector and clears it; this port exists only when there are two or more sources. With a single source, the captured bit clears when the interrupt is taken. An optional mask register can be written at one output index and read back at another. Two more output indices act as global disable and global enable strobes. Sources are assumed to be synchronous to `clk` already.

Top module: `irq_edge_ctrl`

## Requirements
- R1: A source whose invert bit is 0 is captured on a low-to-high transition only. A steady high level or a high-to-low transition captures nothing.
- R2: A source whose invert bit is 1 is captured on a high-to-low transition only. After reset, a source held at its inactive level (low, or high when inverted) produces no capture.
- R3: A capture while an interrupt is in service (between `irq_take_i` and `irq_done_i`) still sets its trigger bit, but it raises no request, either then or after `irq_done_i`.
- R4: With two or more sources, `rd_data_o` at index TRIG_PORT shows the trigger vector, with bit i for source i. A read strobe at that index clears the vector on the next clock.
- R5: With one source, no trigger port exists. Index TRIG_PORT reads 0. The pending state clears when `irq_take_i` is asserted, so no request follows `irq_done_i` without a new transition.
- R6: When the mask is present, a write strobe at index MASK_WR_PORT loads `wr_data_o` into the mask, and index MASK_RD_PORT reads it back. A transition on a source whose mask bit is 0 is not captured and raises no request.
- R7: The mask resets to MASK_INIT. The default for MASK_INIT is all ones.
- R8: Clearing a mask bit after its transition has been captured leaves both the trigger bit and the pending request in place.
- R9: The global enable resets to off. A write strobe at GIE_OFF_PORT blocks `irq_req_o` from the next cycle. A write strobe at GIE_ON_PORT releases a request that is already pending.
- R10: Once raised, `irq_req_o` stays high until the cycle after `irq_take_i`, and it is low in that cycle.
- R11: If a clearing read and a new transition on a source fall in the same cycle, that source's trigger bit is set afterwards.
- R12: A read index that matches no present port returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | N_SRC | Interrupt source levels |
| rd_stb_i | input | 1 | Input-port read strobe |
| rd_idx_i | input | IDX_W | Input-port index |
| rd_data_o | output | N_SRC | Read data for the addressed port |
| wr_stb_i | input | 1 | Output-port write strobe |
| wr_idx_i | input | IDX_W | Output-port index |
| wr_data_i | input | N_SRC | Write data (mask value) |
| irq_take_i | input | 1 | Core accepts the interrupt and enters service |
| irq_done_i | input | 1 | Core returns from the interrupt |
| irq_req_o | output | 1 | Interrupt request to the core |

## Verification
Stimulus includes single transitions in both directions on normal and inverted sources, and steady levels held for several cycles. This separates true edge detection from level sensing and from detection of the wrong polarity. Transitions are placed during service, under a cleared mask, with the mask cleared after the capture, and with the global enable off. These show which gate acts at capture time and which acts only on the request. A transition landing on the same cycle as a clearing read shows which of the two has priority. A second, single-source build with a zero mask reset shows take-based clearing and a non-default mask reset.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned IDX_W = 8;
  typedef logic [IDX_W-1:0] port_idx_t;

  function automatic logic idx_match(input port_idx_t idx, input int unsigned addr);
    return idx == port_idx_t'(addr);
  endfunction
endpackage

// File: rtl/irqc_edge_detect.sv
module irqc_edge_detect #(
  parameter int unsigned N_SRC = 8,
  parameter logic [N_SRC-1:0] INV_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  output logic [N_SRC-1:0] edge_o
);
  logic [N_SRC-1:0] prev_q;

  // Normalise both samples to active-high, then look for inactive -> active.
  function automatic logic [N_SRC-1:0] qual_edge(input logic [N_SRC-1:0] prev,
                                                 input logic [N_SRC-1:0] cur);
    return (cur ^ INV_MASK) & ~(prev ^ INV_MASK);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= INV_MASK;
    else        prev_q <= src_i;
  end

  assign edge_o = qual_edge(prev_q, src_i);

  // R2: an edge means the source left its previous level.
  assert_edge_needs_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_o & ~(src_i ^ prev_q)) == '0));
endmodule

// File: rtl/irqc_trigger_capture.sv
module irqc_trigger_capture #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] edge_i,
  input  logic             clr_i,
  output logic [N_SRC-1:0] trig_o
);
  logic [N_SRC-1:0] trig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) trig_q <= '0;
    else        trig_q <= (trig_q & ~{N_SRC{clr_i}}) | edge_i;
  end

  assign trig_o = trig_q;

  assert_new_edge_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_i) |=> ((trig_q & $past(edge_i)) == $past(edge_i)));

  assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(|edge_i)) |=> (trig_q == '0));
endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
  parameter int unsigned N_SRC = 8,
  parameter bit PRESENT = 1'b1,
  parameter logic [N_SRC-1:0] MASK_INIT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [N_SRC-1:0] wr_data_i,
  output logic [N_SRC-1:0] mask_o
);
  generate
    if (PRESENT) begin : g_reg
      logic [N_SRC-1:0] mask_q;
      always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= MASK_INIT;
        else if (wr_en_i) mask_q <= wr_data_i;
      end
      assign mask_o = mask_q;

      assert_mask_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (mask_o == $past(wr_data_i)));
    end else begin : g_const
      assign mask_o = MASK_INIT;
    end
  endgenerate
endmodule

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC        = 8,
  parameter logic [N_SRC-1:0] INV_MASK  = '0,
  parameter bit          MASK_PRESENT = 1'b1,
  parameter bit          MASK_READ    = 1'b1,
  parameter logic [N_SRC-1:0] MASK_INIT = '1,
  parameter int unsigned TRIG_PORT    = 1,
  parameter int unsigned MASK_RD_PORT = 2,
  parameter int unsigned MASK_WR_PORT = 3,
  parameter int unsigned GIE_OFF_PORT = 4,
  parameter int unsigned GIE_ON_PORT  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             rd_stb_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [N_SRC-1:0] rd_data_o,
  input  logic             wr_stb_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [N_SRC-1:0] wr_data_i,
  input  logic             irq_take_i,
  input  logic             irq_done_i,
  output logic             irq_req_o
);
  localparam bit TRIG_READABLE = (N_SRC > 1);
  localparam bit MASK_READABLE = MASK_PRESENT && MASK_READ;

  // Named internal events.
  logic [N_SRC-1:0] edge_raw, edge_en, trig_vec, mask_vec;
  logic trig_clr, mask_wr, gie_off_hit, gie_on_hit, any_edge_en;
  logic gie_q, in_svc_q, pend_q;

  assign mask_wr     = MASK_PRESENT && wr_stb_i && idx_match(wr_idx_i, MASK_WR_PORT);
  assign gie_off_hit = wr_stb_i && idx_match(wr_idx_i, GIE_OFF_PORT);
  assign gie_on_hit  = wr_stb_i && idx_match(wr_idx_i, GIE_ON_PORT);

  irqc_edge_detect #(.N_SRC(N_SRC), .INV_MASK(INV_MASK)) u_edge (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .edge_o(edge_raw));

  irqc_mask_reg #(.N_SRC(N_SRC), .PRESENT(MASK_PRESENT), .MASK_INIT(MASK_INIT)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en_i(mask_wr), .wr_data_i(wr_data_i), .mask_o(mask_vec));

  assign edge_en     = edge_raw & mask_vec;
  assign any_edge_en = |edge_en;

  generate
    if (TRIG_READABLE) begin : g_clr_read
      assign trig_clr = rd_stb_i && idx_match(rd_idx_i, TRIG_PORT);
    end else begin : g_clr_take
      assign trig_clr = irq_take_i;
    end
  endgenerate

  irqc_trigger_capture #(.N_SRC(N_SRC)) u_trig (
    .clk(clk), .rst_n(rst_n), .edge_i(edge_en), .clr_i(trig_clr), .trig_o(trig_vec));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q    <= 1'b0;
      in_svc_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (gie_off_hit)     gie_q <= 1'b0;
      else if (gie_on_hit) gie_q <= 1'b1;

      if (irq_take_i)      in_svc_q <= 1'b1;
      else if (irq_done_i) in_svc_q <= 1'b0;

      if (irq_take_i)                     pend_q <= 1'b0;
      else if (any_edge_en && !in_svc_q)  pend_q <= 1'b1;
    end
  end

  assign irq_req_o = pend_q && gie_q && !in_svc_q;

  always_comb begin
    rd_data_o = '0;
    if (TRIG_READABLE && idx_match(rd_idx_i, TRIG_PORT))
      rd_data_o = trig_vec;
    else if (MASK_READABLE && idx_match(rd_idx_i, MASK_RD_PORT))
      rd_data_o = mask_vec;
  end

  assert_take_drops_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_i |=> !irq_req_o);

  assert_req_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && !irq_take_i && !gie_off_hit) |=> irq_req_o);

  assert_gie_off_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_off_hit && !gie_on_hit) |=> !irq_req_o);

  assert_no_raise_in_service_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc_q && !irq_done_i) |=> !irq_req_o);
endmodule

// File: tb/sim_irq_edge_ctrl.sv
module sim_irq_edge_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TRIG = 1, MRD = 2, MWR = 3, GOFF = 4, GON = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0] src0 = 4'b0100, rd_data0, wr_data0 = '0;
  logic [7:0] rd_idx0 = '0, wr_idx0 = '0;
  logic rd_stb0 = 0, wr_stb0 = 0, take0 = 0, done0 = 0, irq0;

  logic [0:0] src1 = '0, rd_data1, wr_data1 = '0;
  logic [7:0] rd_idx1 = '0, wr_idx1 = '0;
  logic rd_stb1 = 0, wr_stb1 = 0, take1 = 0, done1 = 0, irq1;

  int n_checks = 0, n_fail = 0;

  irq_edge_ctrl #(.N_SRC(4), .INV_MASK(4'b0100)) u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src0), .rd_stb_i(rd_stb0), .rd_idx_i(rd_idx0),
    .rd_data_o(rd_data0), .wr_stb_i(wr_stb0), .wr_idx_i(wr_idx0), .wr_data_i(wr_data0),
    .irq_take_i(take0), .irq_done_i(done0), .irq_req_o(irq0));

  irq_edge_ctrl #(.N_SRC(1), .INV_MASK(1'b0), .MASK_INIT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .src_i(src1), .rd_stb_i(rd_stb1), .rd_idx_i(rd_idx1),
    .rd_data_o(rd_data1), .wr_stb_i(wr_stb1), .wr_idx_i(wr_idx1), .wr_data_i(wr_data1),
    .irq_take_i(take1), .irq_done_i(done1), .irq_req_o(irq1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input bit which, input int idx, output logic [3:0] d);
    if (which) begin rd_stb1 = 1; rd_idx1 = 8'(idx); end
    else       begin rd_stb0 = 1; rd_idx0 = 8'(idx); end
    #1 d = which ? {3'b000, rd_data1} : rd_data0;
    step();
    rd_stb0 = 0; rd_stb1 = 0;
  endtask

  task automatic wr(input bit which, input int idx, input logic [3:0] d);
    if (which) begin wr_stb1 = 1; wr_idx1 = 8'(idx); wr_data1 = d[0]; end
    else       begin wr_stb0 = 1; wr_idx0 = 8'(idx); wr_data0 = d; end
    step();
    wr_stb0 = 0; wr_stb1 = 0;
  endtask

  task automatic take(input bit which);
    if (which) take1 = 1; else take0 = 1;
    step();
    take0 = 0; take1 = 0;
  endtask

  task automatic done(input bit which);
    if (which) done1 = 1; else done0 = 1;
    step();
    done0 = 0; done1 = 0;
  endtask

  task automatic t_reset();
    logic [3:0] d;
    chk("R9 request low after reset", irq0, 0);
    rd(0, MRD, d); chk("R7 default mask reset", d, 4'hF);
    rd(0, TRIG, d); chk("R2 no capture from reset", d, 0);
    rd(0, 7, d); chk("R12 unmapped index", d, 0);
  endtask

  task automatic t_rise();
    logic [3:0] d;
    wr(0, GON, 0);
    src0[0] = 1; step(); chk("R1 rising edge raises request", irq0, 1);
    repeat (3) step(); chk("R10 request held", irq0, 1);
    rd(0, TRIG, d); chk("R4 trigger vector read", d, 4'b0001);
    rd(0, TRIG, d); chk("R4 read cleared vector", d, 0);
    chk("R10 still held before take", irq0, 1);
    take(0); chk("R10 take drops request", irq0, 0);
    done(0);
    src0[0] = 0; step(); rd(0, TRIG, d); chk("R1 falling edge ignored", d, 0);
    chk("R1 no request on fall", irq0, 0);
  endtask

  task automatic t_fall();
    logic [3:0] d;
    src0[2] = 0; step(); chk("R2 inverted source falling edge", irq0, 1);
    rd(0, TRIG, d); chk("R2 inverted bit captured", d, 4'b0100);
    src0[2] = 1; step(); rd(0, TRIG, d); chk("R2 rising ignored on inverted", d, 0);
    take(0); done(0); chk("R10 cleared after service", irq0, 0);
  endtask

  task automatic t_in_service();
    logic [3:0] d;
    src0[1] = 1; step(); chk("R1 bit1 request", irq0, 1);
    take(0);
    src0[3] = 1; step(); chk("R3 no request while in service", irq0, 0);
    rd(0, TRIG, d); chk("R3 capture during service", d, 4'b1010);
    done(0); step(); chk("R3 no request after done", irq0, 0);
  endtask

  task automatic t_mask();
    logic [3:0] d;
    wr(0, MWR, 4'b1110);
    rd(0, MRD, d); chk("R6 mask readback", d, 4'b1110);
    src0[0] = 1; step(); chk("R6 masked edge no request", irq0, 0);
    rd(0, TRIG, d); chk("R6 masked edge not captured", d, 0);
    src0[0] = 0; step();
  endtask

  task automatic t_mask_late();
    logic [3:0] d;
    wr(0, MWR, 4'hF);
    src0[1] = 0; step();
    src0[1] = 1; step(); chk("R8 edge before mask change", irq0, 1);
    wr(0, MWR, 4'b1101);
    rd(0, TRIG, d); chk("R8 captured bit survives mask clear", d, 4'b0010);
    chk("R8 request survives mask clear", irq0, 1);
    take(0); done(0);
    wr(0, MWR, 4'hF);
  endtask

  task automatic t_global();
    logic [3:0] d;
    wr(0, GOFF, 0);
    src0[0] = 1; step(); chk("R9 disabled blocks request", irq0, 0);
    wr(0, GON, 0); chk("R9 enable releases pending", irq0, 1);
    take(0); done(0);
    rd(0, TRIG, d); chk("R9 capture while disabled", d, 4'b0001);
    src0[0] = 0; step();
  endtask

  task automatic t_collide();
    logic [3:0] d;
    src0[3] = 0; step();
    rd_stb0 = 1; rd_idx0 = 8'(TRIG); src0[3] = 1;
    #1 chk("R11 read data before edge", rd_data0, 0);
    step(); rd_stb0 = 0;
    rd(0, TRIG, d); chk("R11 new edge wins over clear", d, 4'b1000);
    chk("R11 request from colliding edge", irq0, 1);
    take(0); done(0);
  endtask

  task automatic t_single();
    logic [3:0] d;
    rd(1, MRD, d); chk("R7 parameter mask reset", d, 0);
    rd(1, TRIG, d); chk("R5 no trigger port", d, 0);
    wr(1, GON, 0);
    src1 = 1; step(); chk("R7 zero mask blocks source", irq1, 0);
    src1 = 0; step();
    wr(1, MWR, 4'b0001);
    src1 = 1; step(); chk("R5 single source request", irq1, 1);
    take(1); chk("R5 take drops request", irq1, 0);
    done(1); step(); chk("R5 pending cleared by take", irq1, 0);
    src1 = 0; step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    step();
    t_reset();
    t_rise();
    t_fall();
    t_in_service();
    t_mask();
    t_mask_late();
    t_global();
    t_collide();
    t_single();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule